// File: doc/BRIEF.md
# HDLC Receive Packet FIFO

This block sits between an HDLC deframer and a host processor and holds received payload bytes until the host collects them. Flag detection, zero-bit removal and CRC checking all happen upstream. The deframer delivers each payload byte on a valid/ready stream, together with three marks: the byte opens a packet, the byte closes a packet, and the packet passed its checks. The block stores the three marks next to the data, so every entry is 11 bits wide. The host can then tell where packets begin and end, and whether to keep them.

The host reads a status word before each data read. The word shows whether the FIFO is empty, the marks of the byte at the head, the half-full level, a sticky overrun flag, and two latched events: packet started and packet ended. A status-read strobe clears the sticky bits. A data-read strobe pops the head byte into a registered read-data output. One interrupt line combines four sources, and each source has its own enable bit: packet start, packet end, FIFO not empty and FIFO half full. The host can therefore switch between waiting for a new packet and draining by fill level.

On the upstream side, `in_ready` is high whenever the FIFO has room. A deframer cannot stall a serial line, so it may present a byte while `in_ready` is low. That byte is dropped and the overrun flag is set. A byte is accepted on any clock edge where `in_valid` and `in_ready` are both high.

Top module: `hdlc_rx_pkt_fifo`

## Requirements
- R1: After reset the status word is 8'h01 (only the empty bit set), `irq` is 0, `rd_data` is 8'h00 and `in_ready` is 1.
- R2: Bytes leave in the order they were accepted. While the FIFO is not empty, status bit 1 shows the head byte's opening mark, bit 2 its closing mark and bit 3 its packet-OK mark. A pop loads the head data byte into `rd_data` on the next clock edge.
- R3: `in_ready` is 0 exactly when 64 entries are held. A byte presented then is dropped, the stored contents stay unchanged, and status bit 5 (overrun) becomes 1 on the next edge.
- R4: A `stat_rd` strobe clears status bits 5, 6 and 7 on the next edge, unless the same edge sets that bit again. In that case setting wins.
- R5: A pop while the FIFO is empty loads 8'h00 into `rd_data` and leaves the read position unchanged. The next byte written is the next byte read.
- R6: Status bit 4 (half full) is 1 when 32 or more entries are held, and 0 otherwise.
- R7: Status bit 6 (packet started) latches on each accepted byte that carries the opening mark. A dropped byte does not set it.
- R8: Status bit 7 (packet ended) latches on each accepted byte that carries the closing mark.
- R9: `irq` equals (bit6 & irq_en[0]) | (bit7 & irq_en[1]) | (not empty & irq_en[2]) | (half & irq_en[3]).
- R10: The FIFO holds exactly 64 entries. All 64 read back intact after a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream byte present |
| in_ready | output | 1 | FIFO has room |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | Byte opens a packet |
| in_eop | input | 1 | Byte closes a packet |
| in_ok | input | 1 | Packet passed checks (meaningful with in_eop) |
| stat_rd | input | 1 | Host status-read strobe; clears sticky bits |
| stat_word | output | 8 | {end_evt, start_evt, overrun, half, ok, close, open, empty} |
| rd_en | input | 1 | Host data-read strobe (pop) |
| rd_data | output | 8 | Byte popped by the last read |
| irq_en | input | 4 | Enables: [0] start, [1] end, [2] not empty, [3] half |
| irq | output | 1 | Combined interrupt |

## Verification
A table of three packets is run through the FIFO: a three-byte good packet, a two-byte bad packet and a one-byte packet that both opens and closes. Comparing the head marks byte by byte shows that the marks stay attached to the right data. A fill to 31, 32 and then 64 entries, followed by one more write, checks the half-full boundary and the full boundary. It also shows that a dropped byte neither corrupts the store nor latches an event. Popping an empty FIFO and then writing one byte shows whether the read pointer moved. The interrupt enables are tried one at a time, which separates each source's contribution.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              opens;
    logic              closes;
    logic              good;
    logic [BYTE_W-1:0] data;
  } hrf_entry_t;

  localparam int unsigned ENTRY_W = $bits(hrf_entry_t);

  // indices of latched events
  localparam int unsigned EV_START = 0;
  localparam int unsigned EV_END   = 1;
  localparam int unsigned EV_OVR   = 2;
  localparam int unsigned EV_N     = 3;

  // interrupt source indices
  localparam int unsigned IQ_START = 0;
  localparam int unsigned IQ_END   = 1;
  localparam int unsigned IQ_NE    = 2;
  localparam int unsigned IQ_HALF  = 3;
  localparam int unsigned IQ_N     = 4;
endpackage

// File: rtl/hrf_store.sv
module hrf_store
  import hrf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned HALF  = DEPTH / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  hrf_entry_t wr_entry,
  input  logic       rd_req,
  output hrf_entry_t head,
  output logic       empty,
  output logic       full,
  output logic       half,
  output logic       wr_acc,
  output logic       wr_drop,
  output logic       rd_acc
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(HALF);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  hrf_entry_t      mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   count;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign half    = (count >= HALF_CNT);
  assign wr_acc  = wr_req && !full;
  assign wr_drop = wr_req && full;
  assign rd_acc  = rd_req && !empty;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_acc) wptr <= bump(wptr);
      if (rd_acc) rptr <= bump(rptr);
      case ({wr_acc, rd_acc})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_req) |=> full); // R3
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> empty); // R5
endmodule

// File: rtl/hrf_events.sv
module hrf_events #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end
  end

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> (q == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set))); // R4
endmodule

// File: rtl/hrf_irq.sv
module hrf_irq #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] src,
  input  logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] gated;
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = src[i] & en[i];
  end
  assign irq = |gated;
endmodule

// File: rtl/hdlc_rx_pkt_fifo.sv
module hdlc_rx_pkt_fifo
  import hrf_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       in_ok,
  input  logic       stat_rd,
  output logic [7:0] stat_word,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic [3:0] irq_en,
  output logic       irq
);
  localparam int unsigned HALF = DEPTH / 2;

  hrf_entry_t wr_entry, head;
  logic empty, full, half, wr_acc, wr_drop, rd_acc;
  logic [EV_N-1:0] ev_set, ev_q;
  logic [IQ_N-1:0] iq_src;
  logic [2:0]      head_tags;

  assign wr_entry = '{opens: in_sop, closes: in_eop, good: in_ok, data: in_data};

  hrf_store #(.DEPTH(DEPTH), .HALF(HALF)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_req(in_valid), .wr_entry(wr_entry),
    .rd_req(rd_en), .head(head),
    .empty(empty), .full(full), .half(half),
    .wr_acc(wr_acc), .wr_drop(wr_drop), .rd_acc(rd_acc)
  );

  always_comb begin
    ev_set = '0;
    ev_set[EV_START] = wr_acc && in_sop;
    ev_set[EV_END]   = wr_acc && in_eop;
    ev_set[EV_OVR]   = wr_drop;
  end

  hrf_events #(.N(EV_N)) u_events (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(stat_rd), .q(ev_q)
  );

  always_comb begin
    iq_src = '0;
    iq_src[IQ_START] = ev_q[EV_START];
    iq_src[IQ_END]   = ev_q[EV_END];
    iq_src[IQ_NE]    = !empty;
    iq_src[IQ_HALF]  = half;
  end

  hrf_irq #(.N(IQ_N)) u_irq (.src(iq_src), .en(irq_en), .irq(irq));

  assign in_ready  = !full;
  assign head_tags = empty ? 3'b000 : {head.good, head.closes, head.opens};
  assign stat_word = {ev_q[EV_END], ev_q[EV_START], ev_q[EV_OVR], half,
                      head_tags, empty};

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= rd_acc ? head.data : 8'h00;
  end

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stat_word[0]) |=> (rd_data == 8'h00)); // R5
  AST_DROP_FLAGS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> stat_word[5]); // R3
  AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop) |=> stat_word[6]); // R7
  AST_END_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop) |=> stat_word[7]); // R8
  AST_IRQ_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_word[0] && irq_en[2]) |-> irq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'b0000) |-> !irq); // R9
endmodule

// File: tb/hdlc_rx_pkt_fifo_test.sv
module hdlc_rx_pkt_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_ok = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic stat_rd = 1'b0, rd_en = 1'b0;
  logic [3:0] irq_en = 4'b0000;
  logic in_ready, irq;
  logic [7:0] stat_word, rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  hdlc_rx_pkt_fifo uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ok(in_ok),
    .stat_rd(stat_rd), .stat_word(stat_word),
    .rd_en(rd_en), .rd_data(rd_data),
    .irq_en(irq_en), .irq(irq)
  );

  // {sop, eop, ok, data}
  localparam logic [10:0] VEC [6] = '{
    {3'b100, 8'hA1}, {3'b000, 8'hB2}, {3'b011, 8'hC3},
    {3'b100, 8'hD4}, {3'b010, 8'hE5},
    {3'b111, 8'hF6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [10:0] e);
    in_valid = 1'b1;
    {in_sop, in_eop, in_ok, in_data} = e;
    @(negedge clk);
    in_valid = 1'b0;
    {in_sop, in_eop, in_ok, in_data} = '0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic sread();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", stat_word, 8'h01);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 in_ready", in_ready, 1'b1);

    // table walk: write all, then check marks and data in order (R2)
    foreach (VEC[i]) push(VEC[i]);
    chk("R7 start latched", stat_word[6], 1'b1);
    chk("R8 end latched", stat_word[7], 1'b1);
    foreach (VEC[i]) begin
      chk("R2 head marks", stat_word[3:1], {VEC[i][8], VEC[i][9], VEC[i][10]});
      pop();
      chk("R2 data order", rd_data, VEC[i][7:0]);
    end
    chk("R2 empty after drain", stat_word[0], 1'b1);
    chk("R2 marks zero when empty", stat_word[3:1], 3'b000);
    sread();
    chk("R4 events cleared", stat_word[7:5], 3'b000);

    // set wins over clear on the same edge (R4, R7)
    stat_rd = 1'b1;
    push({3'b100, 8'h11});
    stat_rd = 1'b0;
    chk("R4 set wins", stat_word[6], 1'b1);
    pop();
    sread();

    // empty pop (R5)
    pop();
    chk("R5 empty pop zero", rd_data, 8'h00);
    push({3'b000, 8'h5A});
    pop();
    chk("R5 pointer unmoved", rd_data, 8'h5A);
    chk("R5 empty again", stat_word[0], 1'b1);

    // fill to boundaries (R6, R10, R3)
    for (int k = 0; k < 31; k++) push({3'b000, 8'(k)});
    chk("R6 half at 31", stat_word[4], 1'b0);
    push({3'b000, 8'd31});
    chk("R6 half at 32", stat_word[4], 1'b1);
    for (int k = 32; k < 63; k++) push({3'b000, 8'(k)});
    chk("R3 ready at 63", in_ready, 1'b1);
    push({3'b000, 8'd63});
    chk("R10 ready low at 64", in_ready, 1'b0);
    sread();
    push({3'b100, 8'hEE});
    chk("R3 overrun set", stat_word[5], 1'b1);
    chk("R7 dropped byte no start", stat_word[6], 1'b0);
    sread();
    chk("R4 overrun cleared", stat_word[5], 1'b0);

    // drain 64 intact (R10, R3)
    begin
      int bad = 0;
      for (int k = 0; k < 64; k++) begin
        pop();
        if (rd_data !== 8'(k)) bad++;
      end
      chk("R10 all 64 intact", bad, 0);
    end
    chk("R3 drop left nothing", stat_word[0], 1'b1);
    sread();

    // interrupt enables (R9)
    irq_en = 4'b0100;
    @(negedge clk);
    chk("R9 ne source idle", irq, 1'b0);
    push({3'b000, 8'h01});
    chk("R9 ne source", irq, 1'b1);
    irq_en = 4'b1001;
    @(negedge clk);
    chk("R9 masked", irq, 1'b0);
    irq_en = 4'b0010;
    push({3'b011, 8'h02});
    chk("R9 end source", irq, 1'b1);
    irq_en = 4'b0001;
    push({3'b100, 8'h03});
    chk("R9 start source", irq, 1'b1);
    sread();
    chk("R9 start cleared", irq, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule